// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital core of a 12-bit successive-approximation analog-to-digital converter. It watches a conversion-start input. On a rising edge it puts the external track/hold into hold and runs a binary search over the trial code. The trial code drives an external voltage-output DAC. A single comparator bit comes back from the analog side and tells the controller whether the sampled input is at or above the current trial code.

Each bit trial takes two clocks, starting from the most significant bit. A fixed number of settle clocks comes before the trials and a fixed number after them. With the default parameters a conversion holds the status output low for exactly 26 clocks. The start input passes through a two-flop synchronizer, so the time from the asynchronous edge to the end of the conversion varies with the phase of that edge against the clock.

While a conversion runs, the active-low busy output is low and the parallel result port is not driven. Once the result is ready, the port drives the result only while chip-select and read are both low. The tri-state pad is expected outside the block: `data_oe` is the pad enable and `data_out` is the value it carries.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A rising edge of `conv_start` starts a conversion. The edge passes through a two-flop synchronizer and an edge detector, so `busy_n` falls on the third rising clock edge after `conv_start` is first sampled high. Holding `conv_start` high does not start another conversion.
- R2: `busy_n` stays low for exactly PRE_CYC + 2*DATA_W + POST_CYC clocks (26 with the defaults DATA_W=12, PRE_CYC=1, POST_CYC=1) and then returns high.
- R3: `dac_code` is cleared to 0 on the edge where `busy_n` falls. For each bit from bit DATA_W-1 down to bit 0, the first of two clocks sets that bit in `dac_code`. The second clock samples `cmp_in` and keeps the bit when `cmp_in` is 1 or clears it when `cmp_in` is 0.
- R4: When the comparator reports 1 exactly when the input is at or above `dac_code`, the result read out equals the input value, for every input from 0 to 2^DATA_W-1.
- R5: While `busy_n` is low, `data_oe` is 0 whatever the values of `cs_n` and `rd_n`.
- R6: When no conversion is running, `data_oe` is 1 and `data_out` equals the last result in the clock after `cs_n` and `rd_n` are both sampled 0. Otherwise `data_oe` is 0 and `data_out` is 0. This also holds before any conversion has run.
- R7: A rising edge of `conv_start` during a running conversion is ignored. Neither the length of that conversion nor its result changes.
- R8: After a synchronous reset, `busy_n` is 1, `hold` is 0, `dac_code` is 0, `data_oe` is 0, `data_out` is 0 and the stored result is 0.
- R9: `hold` is 1 exactly in the clocks where `busy_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Conversion start; its rising edge begins a conversion (asynchronous) |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the DAC output |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| dac_code | output | DATA_W | Trial code to the external DAC |
| hold | output | 1 | Track/hold control, 1 = hold |
| busy_n | output | 1 | Low while converting, high when the result is ready |
| data_oe | output | 1 | Output enable for the result pad |
| data_out | output | DATA_W | Result value for the pad, 0 when not enabled |

## Verification
The bench builds the block with its defaults: DATA_W=12, PRE_CYC=1 and POST_CYC=1. With these values the 26-clock window can be counted exactly, and the full code range, including 0 and 4095, can be converted in a short run. The single pre-trial and post-trial clocks sit right next to the first set and the final load. Any off-by-one in the sequencer therefore shows up at once in the length check and in the per-cycle comparison of the trial code. A start pulse inside a conversion and a start level held across the whole conversion exercise the edge detector against the busy interlock.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_PRE,
    SEQ_SET,
    SEQ_CMP,
    SEQ_POST
  } seq_state_t;
endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[DEPTH-2:0], async_in};
    end
  end

  // edge between the last synchronizer stage and its delayed copy
  assign rise = sync_q[DEPTH-2] & ~sync_q[DEPTH-1];
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int PRE_CYC  = 1,
  parameter int POST_CYC = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_rise,
  output logic                      clr_code,
  output logic                      set_en,
  output logic                      cmp_en,
  output logic [$clog2(DATA_W)-1:0] bit_idx,
  output logic                      finish,
  output logic                      busy_n,
  output logic                      busy_n_nxt,
  output logic                      hold
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int MAXC   = (PRE_CYC > POST_CYC) ? PRE_CYC : POST_CYC;
  localparam int CNT_W  = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_CYC - 1);
  localparam logic [CNT_W-1:0] POST_LAST = CNT_W'(POST_CYC - 1);
  localparam logic [IDX_W-1:0] MSB_IDX   = IDX_W'(DATA_W - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    busy_n_nxt = busy_n;
    clr_code   = 1'b0;
    set_en     = 1'b0;
    cmp_en     = 1'b0;
    finish     = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start_rise) begin
          state_d    = SEQ_PRE;
          cnt_d      = '0;
          clr_code   = 1'b1;
          busy_n_nxt = 1'b0;
        end
      end
      SEQ_PRE: begin
        if (cnt_q == PRE_LAST) begin
          state_d = SEQ_SET;
          idx_d   = MSB_IDX;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SEQ_SET: begin
        set_en  = 1'b1;
        state_d = SEQ_CMP;
      end
      SEQ_CMP: begin
        cmp_en = 1'b1;
        if (idx_q == '0) begin
          state_d = SEQ_POST;
          cnt_d   = '0;
        end else begin
          idx_d   = idx_q - 1'b1;
          state_d = SEQ_SET;
        end
      end
      SEQ_POST: begin
        if (cnt_q == POST_LAST) begin
          state_d    = SEQ_IDLE;
          finish     = 1'b1;
          busy_n_nxt = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      idx_q   <= MSB_IDX;
      busy_n  <= 1'b1;
      hold    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      busy_n  <= busy_n_nxt;
      hold    <= ~busy_n_nxt;
    end
  end

  assign bit_idx = idx_q;
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int DATA_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      set_en,
  input  logic                      cmp_en,
  input  logic [$clog2(DATA_W)-1:0] idx,
  input  logic                      cmp_in,
  output logic [DATA_W-1:0]         code
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code <= '0;
    end else if (set_en) begin
      code[idx] <= 1'b1;
    end else if (cmp_en) begin
      code[idx] <= cmp_in;
    end
  end
endmodule

// File: rtl/sar_read_port.sv
module sar_read_port #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] code_in,
  input  logic              ready_nxt,
  input  logic              cs_n,
  input  logic              rd_n,
  output logic              data_oe,
  output logic [DATA_W-1:0] data_out
);
  logic [DATA_W-1:0] result_q;
  logic [DATA_W-1:0] result_d;
  logic              drive;

  assign result_d = load ? code_in : result_q;
  assign drive    = ready_nxt & ~cs_n & ~rd_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      result_q <= result_d;
      data_oe  <= drive;
      data_out <= drive ? result_d : '0;
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int DATA_W      = 12,
  parameter int PRE_CYC     = 1,
  parameter int POST_CYC    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_start,
  input  logic              cmp_in,
  input  logic              cs_n,
  input  logic              rd_n,
  output logic [DATA_W-1:0] dac_code,
  output logic              hold,
  output logic              busy_n,
  output logic              data_oe,
  output logic [DATA_W-1:0] data_out
);
  localparam int IDX_W = $clog2(DATA_W);

  logic             start_rise;
  logic             clr_code, set_en, cmp_en, finish, busy_n_nxt;
  logic [IDX_W-1:0] bit_idx;

  sar_start_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (conv_start),
    .rise     (start_rise)
  );

  sar_sequencer #(
    .DATA_W   (DATA_W),
    .PRE_CYC  (PRE_CYC),
    .POST_CYC (POST_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_rise (start_rise),
    .clr_code   (clr_code),
    .set_en     (set_en),
    .cmp_en     (cmp_en),
    .bit_idx    (bit_idx),
    .finish     (finish),
    .busy_n     (busy_n),
    .busy_n_nxt (busy_n_nxt),
    .hold       (hold)
  );

  sar_trial_reg #(.DATA_W(DATA_W)) u_trial (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_code),
    .set_en (set_en),
    .cmp_en (cmp_en),
    .idx    (bit_idx),
    .cmp_in (cmp_in),
    .code   (dac_code)
  );

  sar_read_port #(.DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .load      (finish),
    .code_in   (dac_code),
    .ready_nxt (busy_n_nxt),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .data_oe   (data_oe),
    .data_out  (data_out)
  );
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int DATA_W   = 12,
  parameter int PRE_CYC  = 1,
  parameter int POST_CYC = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rd_n,
  input logic [DATA_W-1:0] dac_code,
  input logic              hold,
  input logic              busy_n,
  input logic              data_oe,
  input logic [DATA_W-1:0] data_out
);
  localparam int TOTAL = PRE_CYC + 2 * DATA_W + POST_CYC;

  int unsigned low_cnt;

  always_ff @(posedge clk) begin
    if (rst || busy_n) low_cnt <= 0;
    else               low_cnt <= low_cnt + 1;
  end

  assert_busy_len_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n) |-> (low_cnt == TOTAL));

  assert_code_clear_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_n) |-> (dac_code == '0));

  assert_no_drive_busy_R5: assert property (@(posedge clk) disable iff (rst)
    !busy_n |-> !data_oe);

  assert_read_gate_R6: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |=> !data_oe);

  assert_quiet_data_R6: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_out == '0));

  assert_hold_track_R9: assert property (@(posedge clk) disable iff (rst)
    hold == !busy_n);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
  .DATA_W   (DATA_W),
  .PRE_CYC  (PRE_CYC),
  .POST_CYC (POST_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .rd_n     (rd_n),
  .dac_code (dac_code),
  .hold     (hold),
  .busy_n   (busy_n),
  .data_oe  (data_oe),
  .data_out (data_out)
);

// File: tb/test_sar_conv_ctrl.sv
`timescale 1ns/1ps
module test_sar_conv_ctrl;
  localparam int W     = 12;
  localparam int PRE   = 1;
  localparam int POST  = 1;
  localparam int TOTAL = PRE + 2 * W + POST;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_start = 1'b0;
  logic cs_n = 1'b1;
  logic rd_n = 1'b1;
  logic cmp_in;
  logic [W-1:0] dac_code, data_out;
  logic hold, busy_n, data_oe;
  int vin = 0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign cmp_in = (vin >= int'(dac_code));

  sar_conv_ctrl #(.DATA_W(W), .PRE_CYC(PRE), .POST_CYC(POST)) i_sar_conv_ctrl (
    .clk(clk), .rst(rst), .conv_start(conv_start), .cmp_in(cmp_in),
    .cs_n(cs_n), .rd_n(rd_n), .dac_code(dac_code), .hold(hold),
    .busy_n(busy_n), .data_oe(data_oe), .data_out(data_out)
  );

  // behavioural reference
  bit     smp[3];
  int     ph = -1;
  bit     m_busy = 1'b1;
  bit     m_oe = 1'b0;
  int     m_code = 0;
  int     m_res = 0;
  int     m_out = 0;

  always @(posedge clk) begin
    if (rst) begin
      smp = '{0, 0, 0};
      ph = -1; m_busy = 1'b1; m_oe = 1'b0; m_code = 0; m_res = 0; m_out = 0;
    end else begin
      bit edge_seen;
      edge_seen = smp[1] && !smp[2];
      smp[2] = smp[1]; smp[1] = smp[0]; smp[0] = conv_start;
      if (ph < 0) begin
        if (edge_seen) begin ph = 0; m_code = 0; m_busy = 1'b0; end
      end else begin
        int q;
        q = ph - PRE;
        if (q >= 0 && q < 2 * W) begin
          int b;
          b = W - 1 - q / 2;
          if (q % 2 == 0) m_code = m_code | (1 << b);
          else if (!(vin >= m_code)) m_code = m_code & ~(1 << b);
        end
        if (ph == TOTAL - 1) begin
          ph = -1; m_busy = 1'b1; m_res = m_code;
        end else begin
          ph = ph + 1;
        end
      end
      m_oe  = m_busy && !cs_n && !rd_n;
      m_out = m_oe ? m_res : 0;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2 busy_n", int'(busy_n), int'(m_busy));
      check("R9 hold", int'(hold), int'(!m_busy));
      check("R3 dac_code", int'(dac_code), m_code);
      check(m_busy ? "R6 data_oe" : "R5 data_oe", int'(data_oe), int'(m_oe));
      check("R6 data_out", int'(data_out), m_out);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // one conversion; restart=1 puts a second start edge mid-conversion (R7),
  // level=1 holds conv_start high until well after the end (R1)
  task automatic run_conv(int v, bit restart, bit level, bit read_during);
    int lows;
    vin = v;
    if (read_during) begin cs_n = 1'b0; rd_n = 1'b0; end
    tick();
    conv_start = 1'b1;
    repeat (3) tick();
    if (!level) conv_start = 1'b0;
    while (busy_n) tick();
    lows = 0;
    while (!busy_n) begin
      @(negedge clk);
      if (!busy_n) begin
        lows++;
        if (read_during) check("R5 no drive while busy", int'(data_oe), 0);
        if (restart && lows == 6) conv_start = 1'b1;
        if (restart && lows == 10) conv_start = 1'b0;
      end
    end
    check(restart ? "R7 length with restart" : "R2 length", lows, TOTAL);
    if (level) begin
      repeat (10) tick();
      check("R1 level does not retrigger", int'(busy_n), 1);
      conv_start = 1'b0;
    end
    cs_n = 1'b0; rd_n = 1'b0;
    tick(); tick();
    @(negedge clk);
    check(restart ? "R7 result" : "R4 result", int'(data_out), v);
    check("R6 oe on read", int'(data_oe), 1);
    tick(); rd_n = 1'b1; tick();
    @(negedge clk);
    check("R6 rd_n high idle", int'(data_oe), 0);
    tick(); rd_n = 1'b0; cs_n = 1'b1; tick();
    @(negedge clk);
    check("R6 cs_n high idle", int'(data_oe), 0);
    tick(); cs_n = 1'b1; rd_n = 1'b1; tick();
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    check("R8 busy_n reset", int'(busy_n), 1);
    check("R8 hold reset", int'(hold), 0);
    check("R8 dac_code reset", int'(dac_code), 0);
    check("R8 data_oe reset", int'(data_oe), 0);
    // read before any conversion: drives the zero result (R8, R6)
    tick(); cs_n = 1'b0; rd_n = 1'b0; tick();
    @(negedge clk);
    check("R8 result after reset", int'(data_out), 0);
    check("R6 idle read enable", int'(data_oe), 1);
    tick(); cs_n = 1'b1; rd_n = 1'b1; tick();

    run_conv(0, 0, 0, 0);
    run_conv(4095, 0, 0, 1);
    run_conv(2048, 0, 0, 0);
    run_conv(2047, 0, 0, 1);
    run_conv(12'hA5A, 1, 0, 0);
    run_conv(1, 0, 1, 0);
    run_conv(12'h555, 0, 0, 1);
    for (int i = 0; i < 6; i++) run_conv((i * 1237 + 311) % 4096, 0, 0, 0);

    // start edge arriving during reset is lost (R8)
    rst = 1'b1; vin = 77; conv_start = 1'b1; tick(); tick(); conv_start = 1'b0;
    tick(); rst = 1'b0; repeat (5) tick();
    @(negedge clk);
    check("R8 no conversion after reset", int'(busy_n), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule